// File: doc/BRIEF.md
# Converter Interface Mode Tracker

This block follows which of two interface modes an attached serial converter is in, by watching the same three control lines the converter sees: an active-low convert-start, an active-low chip-select and the serial clock. In the convert-start mode, which is the mode after reset, a falling convert-start begins a conversion that runs for a fixed time. In the clock-driven mode, the serial clock paces conversion and data transfer. Only this mode permits the converter to power down.

All three lines are asynchronous to the system clock. They are brought in through two-flop synchronisers and edge detectors. A serial clock transition of either direction during a running conversion, with convert-start still low, ends that conversion and moves the tracker to the clock-driven mode. When in the clock-driven mode, a chip-select low interval with no serial clock activity brings the tracker back to the convert-start mode. The host logic uses the mode output to decide how to drive the converter, and uses the termination pulse to discard a conversion that never finished.

Top module: `conv_mode_tracker`

## Requirements
- R1: After synchronous reset, `mode_o` is 0 (convert-start mode), `pdn_ok_o` is 0 and neither pulse output is high.
- R2: In the convert-start mode, a synchronised serial clock transition of either direction (rising or falling) while the conversion window is open and convert-start is low sets `mode_o` to 1 (clock-driven mode).
- R3: The conversion window opens on a synchronised falling edge of convert-start in the convert-start mode and stays open for `CONV_CYCLES` system clocks. Serial clock edges after the window closes, or while convert-start is high, leave the mode unchanged.
- R4: The switch described in R2 raises `conv_abort_o` for exactly one clock cycle, and it goes high in the same cycle in which `mode_o` becomes 1.
- R5: In the clock-driven mode, a rising chip-select that ends a low interval with no serial clock transitions sets `mode_o` back to 0.
- R6: In the clock-driven mode, a chip-select low interval that contains serial clock transitions leaves the mode at 1. Convert-start activity in this mode has no effect and raises no termination pulse.
- R7: In the convert-start mode, chip-select pulses (with or without serial clock activity) leave the mode at 0.
- R8: `pdn_ok_o` is 1 exactly while `mode_o` is 1, and it drops in the same cycle that the mode returns to 0.
- R9: Every change of `mode_o` is marked by a one-cycle pulse on `mode_chg_o`. No pulse appears without a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| convst_n_in | input | 1 | Convert-start line, active low, asynchronous |
| cs_n_in | input | 1 | Chip-select line, active low, asynchronous |
| sclk_in | input | 1 | Serial clock line, asynchronous |
| mode_o | output | 1 | Current mode: 0 convert-start, 1 clock-driven |
| mode_chg_o | output | 1 | One-cycle pulse on each mode change |
| conv_abort_o | output | 1 | One-cycle pulse when a running conversion is ended by serial clock activity |
| pdn_ok_o | output | 1 | Power-down permitted (clock-driven mode only) |

## Verification
The mode-entry rule is tried with four serial clock patterns. These are a lone rising glitch and a lone falling transition inside an open window, an edge after the window has run out with convert-start still low, and an edge while convert-start is high. Together these separate the window timing and the convert-start gate, and show that both edge directions count. The exit rule is tried with a chip-select interval that carries clocks and one that is silent, which separates the clock-seen flag from the chip-select edge detection. Chip-select pulses in the default mode and convert-start pulses in the clock-driven mode show that each mode ignores the other mode's controls.

// File: rtl/conv_mode_pkg.sv
package conv_mode_pkg;

    typedef enum logic {
        MODE_CONVST = 1'b0,
        MODE_SCLK   = 1'b1
    } mode_t;

    // bit positions of the synchronised control vector
    localparam int IDX_CONVST = 0;
    localparam int IDX_CS     = 1;
    localparam int IDX_SCLK   = 2;
    localparam int N_CTRL     = 3;
    // idle levels: convert-start high, chip-select high, serial clock low
    localparam logic [N_CTRL-1:0] CTRL_IDLE = 3'b011;

    typedef struct packed {
        logic convst_fall;
        logic cs_fall;
        logic cs_rise;
        logic cs_low;
        logic convst_low;
        logic sclk_edge;
    } ctrl_ev_t;

    function automatic int conv_cycles(input int clk_mhz, input int conv_ns);
        return (clk_mhz * conv_ns) / 1000;
    endfunction

endpackage

// File: rtl/conv_mode_sync.sv
module conv_mode_sync
    import conv_mode_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CTRL-1:0] raw_i,
    output logic [N_CTRL-1:0] lvl_o,
    output logic [N_CTRL-1:0] tog_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < N_CTRL; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{CTRL_IDLE[b]}};
                prev_q  <= CTRL_IDLE[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw_i[b]};
                prev_q  <= chain_q[LAST];
            end
        end

        assign lvl_o[b] = chain_q[LAST];
        assign tog_o[b] = chain_q[LAST] ^ prev_q;
    end
endmodule

// File: rtl/conv_mode_window.sv
module conv_mode_window #(
    parameter int CONV_CYCLES = 660
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic kill_i,
    output logic open_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || kill_i) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign open_o = (left_q != '0);
endmodule

// File: rtl/conv_mode_fsm.sv
module conv_mode_fsm
    import conv_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctrl_ev_t ev_i,
    input  logic     win_open_i,
    output logic     enter_o,
    output mode_t    mode_o,
    output logic     chg_o,
    output logic     abort_o
);
    mode_t mode_q;
    logic  seen_q;
    logic  chg_q;
    logic  abort_q;
    logic  leave;

    assign enter_o = (mode_q == MODE_CONVST) && win_open_i && ev_i.convst_low && ev_i.sclk_edge;
    assign leave   = (mode_q == MODE_SCLK) && ev_i.cs_rise && !seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_CONVST;
            seen_q  <= 1'b0;
            chg_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            chg_q   <= enter_o || leave;
            abort_q <= enter_o;
            if (enter_o) begin
                mode_q <= MODE_SCLK;
            end else if (leave) begin
                mode_q <= MODE_CONVST;
            end
            if (ev_i.cs_fall) begin
                seen_q <= 1'b0;
            end else if (ev_i.cs_low && ev_i.sclk_edge) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign mode_o  = mode_q;
    assign chg_o   = chg_q;
    assign abort_o = abort_q;
endmodule

// File: rtl/conv_mode_tracker.sv
module conv_mode_tracker
    import conv_mode_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int CONV_NS     = 3300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic convst_n_in,
    input  logic cs_n_in,
    input  logic sclk_in,
    output logic mode_o,
    output logic mode_chg_o,
    output logic conv_abort_o,
    output logic pdn_ok_o
);
    localparam int CONV_CYCLES = conv_cycles(CLK_MHZ, CONV_NS);

    logic [N_CTRL-1:0] raw;
    logic [N_CTRL-1:0] lvl;
    logic [N_CTRL-1:0] tog;
    ctrl_ev_t          ev;
    logic              win_open;
    logic              enter;
    mode_t             mode;

    assign raw[IDX_CONVST] = convst_n_in;
    assign raw[IDX_CS]     = cs_n_in;
    assign raw[IDX_SCLK]   = sclk_in;

    conv_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (raw),
        .lvl_o (lvl),
        .tog_o (tog)
    );

    always_comb begin
        ev.convst_fall = tog[IDX_CONVST] && !lvl[IDX_CONVST];
        ev.convst_low  = !lvl[IDX_CONVST];
        ev.cs_fall     = tog[IDX_CS] && !lvl[IDX_CS];
        ev.cs_rise     = tog[IDX_CS] && lvl[IDX_CS];
        ev.cs_low      = !lvl[IDX_CS];
        ev.sclk_edge   = tog[IDX_SCLK];
    end

    conv_mode_window #(.CONV_CYCLES(CONV_CYCLES)) u_win (
        .clk     (clk),
        .rst     (rst),
        .start_i (ev.convst_fall && (mode == MODE_CONVST)),
        .kill_i  (enter),
        .open_o  (win_open)
    );

    conv_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .win_open_i (win_open),
        .enter_o    (enter),
        .mode_o     (mode),
        .chg_o      (mode_chg_o),
        .abort_o    (conv_abort_o)
    );

    assign mode_o   = (mode == MODE_SCLK);
    assign pdn_ok_o = (mode == MODE_SCLK);
endmodule

// File: rtl/conv_mode_tracker_chk.sv
module conv_mode_tracker_chk (
    input logic clk,
    input logic rst,
    input logic mode_o,
    input logic mode_chg_o,
    input logic conv_abort_o,
    input logic pdn_ok_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!mode_o && !mode_chg_o && !conv_abort_o && !pdn_ok_o));

    assert_rise_needs_abort_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_o) |-> conv_abort_o);

    assert_abort_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        conv_abort_o |-> (mode_o && mode_chg_o) ##1 !conv_abort_o);

    assert_pdn_drops_with_mode_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_o) |-> !pdn_ok_o);

    assert_change_marked_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> mode_chg_o);

    assert_chg_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        mode_chg_o |=> !mode_chg_o);
endmodule

bind conv_mode_tracker conv_mode_tracker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_o       (mode_o),
    .mode_chg_o   (mode_chg_o),
    .conv_abort_o (conv_abort_o),
    .pdn_ok_o     (pdn_ok_o)
);

// File: tb/conv_mode_tracker_tb_top.sv
module conv_mode_tracker_tb_top;
    localparam int CONV_CYC = 660;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic convst_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mode, chg, abort_p, pdn;

    int n_chk = 0;
    int n_bad = 0;
    int abort_cnt = 0;
    int chg_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    conv_mode_tracker dut_i (
        .clk          (clk),
        .rst          (rst),
        .convst_n_in  (convst_n),
        .cs_n_in      (cs_n),
        .sclk_in      (sclk),
        .mode_o       (mode),
        .mode_chg_o   (chg),
        .conv_abort_o (abort_p),
        .pdn_ok_o     (pdn)
    );

    always @(negedge clk) begin
        if (abort_p) abort_cnt++;
        if (chg) chg_cnt++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; cyc(4);
        sclk = 1'b0; cyc(4);
    endtask

    task automatic t_reset();
        check("R1 mode", mode, 0);
        check("R1 pdn", pdn, 0);
        check("R1 pulses", chg_cnt + abort_cnt, 0);
    endtask

    task automatic t_quiet_conversion();
        int c0 = chg_cnt;
        convst_n = 1'b0; cyc(CONV_CYC + 20);
        convst_n = 1'b1; cyc(10);
        check("R3 quiet conversion mode", mode, 0);
        check("R3 quiet conversion chg", chg_cnt - c0, 0);
    endtask

    task automatic t_late_edge();
        int a0 = abort_cnt;
        convst_n = 1'b0; cyc(CONV_CYC + 30);
        sclk_pulse(); cyc(6);
        check("R3 edge after window mode", mode, 0);
        check("R3 edge after window abort", abort_cnt - a0, 0);
        convst_n = 1'b1; cyc(6);
    endtask

    task automatic t_convst_high_edge();
        sclk_pulse(); sclk_pulse(); cyc(6);
        check("R3 edge with convst high", mode, 0);
    endtask

    task automatic t_cs_in_mode0();
        int c0 = chg_cnt;
        cs_n = 1'b0; cyc(8); cs_n = 1'b1; cyc(8);
        cs_n = 1'b0; sclk_pulse(); cs_n = 1'b1; cyc(8);
        check("R7 cs pulses mode", mode, 0);
        check("R7 cs pulses chg", chg_cnt - c0, 0);
    endtask

    task automatic t_glitch_enter();
        int a0 = abort_cnt;
        int c0 = chg_cnt;
        convst_n = 1'b0; cyc(50);
        sclk = 1'b1; cyc(8);
        check("R2 rising glitch mode", mode, 1);
        check("R4 abort pulse count", abort_cnt - a0, 1);
        check("R9 chg pulse count", chg_cnt - c0, 1);
        check("R8 pdn in clock mode", pdn, 1);
        sclk = 1'b0; cyc(4);
        convst_n = 1'b1; cyc(6);
        check("R6 stays after glitch", mode, 1);
    endtask

    task automatic t_busy_cs();
        int c0 = chg_cnt;
        cs_n = 1'b0; cyc(4);
        sclk_pulse(); sclk_pulse(); sclk_pulse();
        cs_n = 1'b1; cyc(8);
        check("R6 clocked cs mode", mode, 1);
        check("R6 clocked cs chg", chg_cnt - c0, 0);
    endtask

    task automatic t_convst_in_mode1();
        int a0 = abort_cnt;
        convst_n = 1'b0; cyc(20);
        sclk_pulse();
        convst_n = 1'b1; cyc(8);
        check("R6 convst ignored mode", mode, 1);
        check("R6 convst ignored abort", abort_cnt - a0, 0);
    endtask

    task automatic t_exit(input string tag);
        int c0 = chg_cnt;
        int a0 = abort_cnt;
        cs_n = 1'b0; cyc(10);
        cs_n = 1'b1; cyc(8);
        check({"R5 exit mode ", tag}, mode, 0);
        check({"R8 pdn cleared ", tag}, pdn, 0);
        check({"R9 exit chg ", tag}, chg_cnt - c0, 1);
        check({"R5 exit abort ", tag}, abort_cnt - a0, 0);
    endtask

    task automatic t_falling_enter();
        int a0 = abort_cnt;
        sclk = 1'b1; cyc(8);
        check("R3 setup rise ignored", mode, 0);
        convst_n = 1'b0; cyc(20);
        sclk = 1'b0; cyc(8);
        check("R2 falling edge mode", mode, 1);
        check("R4 falling edge abort", abort_cnt - a0, 1);
        convst_n = 1'b1; cyc(6);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(3);
        t_reset();
        t_quiet_conversion();
        t_late_edge();
        t_convst_high_edge();
        t_cs_in_mode0();
        t_glitch_enter();
        t_busy_cs();
        t_convst_in_mode1();
        t_exit("first");
        t_falling_enter();
        t_exit("second");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule